// File: doc/BRIEF.md
# Word-Sliced Modular Adder/Subtractor

This block returns the sum or the difference of two operands modulo an n-bit odd modulus, where n is the word width times the word count. Both operands are expected to be already reduced, i.e. strictly below the modulus. A single control input picks addition or subtraction. The caller supplies the modulus and also its negation modulo 2^n, so the block never has to negate the modulus itself.

The datapath is cut into equal words. Each word computes two candidates in parallel:

- **Direct candidate:** A + B, or A - B formed as A plus the inverted B plus one.
- **Corrected candidate:** the direct word plus either the negated modulus (add) or the modulus (subtract).

Each candidate has its own parallel-prefix carry network that resolves the carry into every word. The two final carry-outs drive one common select, and that select picks, word by word, which candidate becomes the result. The result is held in an output register that loads when the enable input is high.

Top module: `modaddsub`

## Requirements
- R1: With sub_i = 0 and operands below P, the registered result equals A + B - P when A + B ≥ P (including when A + B ≥ 2^n), and A + B otherwise.
- R2: With sub_i = 1 and operands below P, the registered result equals A - B + P when A < B, and A - B otherwise.
- R3: Whenever both operands are below P, the result loaded into r_o is below P.
- R4: r_o loads a new result on the rising clock edge where en_i is 1, so the result appears one cycle after the inputs. While en_i is 0, r_o keeps its value.
- R5: r_o is 0 while rst_n is low. The release of the reset is taken through a two-stage synchronizer, and r_o stays 0 until the first enabled load.
- R6: The carry-in of word 0 is sub_i on the direct path and 0 on the corrected path. In both paths, the carry into word k+1 equals the generate of word k OR (the propagate of word k AND the carry into word k).
- R7: Boundary operands give exact values:
  - A = B with subtraction gives 0.
  - A = 0 with subtraction gives P - B.
  - A + B = P with addition gives 0.
  - A = B = P - 1 with addition gives P - 2.
- R8: A carry that travels through every word boundary, including an addition whose sum exceeds 2^n - 1 because P lies close to 2^n, still gives the correctly reduced result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| en_i | input | 1 | Clock enable for the result register |
| sub_i | input | 1 | 0 = modular addition, 1 = modular subtraction |
| a_i | input | WORD_W*NWORDS | First operand, below P |
| b_i | input | WORD_W*NWORDS | Second operand, below P |
| p_i | input | WORD_W*NWORDS | Modulus P |
| ip_i | input | WORD_W*NWORDS | Negated modulus, 2^n - P |
| r_o | output | WORD_W*NWORDS | Registered result |

## Verification
Some properties are checked by assertions on every cycle:

- The ripple relation between the word carries and the word generate/propagate signals, in both prefix networks.
- The range bound on the result.
- The add and subtract formulas, for every enabled load.
- The hold of r_o while the enable is low.

Other behaviour can only be shown by the bench's scenarios:

- The reset value.
- The exact boundary operands: A = B, A = 0, P - 1, and A + B = P.
- Carries that ripple through every word.
- An addition that overflows 2^n because the modulus sits near the top of the range.

// File: rtl/modaddsub_pkg.sv
package modaddsub_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;
endpackage

// File: rtl/mas_carry_proj.sv
module mas_carry_proj #(
  parameter int NWORDS = 4
) (
  input  logic [NWORDS-1:0] gen_i,
  input  logic [NWORDS-1:0] prop_i,
  input  logic              cin_i,
  output logic [NWORDS:0]   carry_o
);
  localparam int NODES  = NWORDS + 1;
  localparam int LEVELS = $clog2(NODES);

  logic [LEVELS:0][NWORDS:0] g_lv;
  logic [LEVELS:0][NWORDS:0] p_lv;

  // Kogge-Stone prefix: node 0 is the carry-in, node k+1 is word k
  always_comb begin
    g_lv[0] = {gen_i, cin_i};
    p_lv[0] = {prop_i, 1'b0};
    for (int lv = 0; lv < LEVELS; lv++) begin
      for (int j = 0; j < NODES; j++) begin
        if (j >= (1 << lv)) begin
          g_lv[lv+1][j] = g_lv[lv][j] | (p_lv[lv][j] & g_lv[lv][j-(1<<lv)]);
          p_lv[lv+1][j] = p_lv[lv][j] & p_lv[lv][j-(1<<lv)];
        end else begin
          g_lv[lv+1][j] = g_lv[lv][j];
          p_lv[lv+1][j] = p_lv[lv][j];
        end
      end
    end
  end

  assign carry_o = g_lv[LEVELS];

  always_comb begin
    for (int k = 0; k < NWORDS; k++) begin
      // R6
      ripple_agree_chk: assert (carry_o[k+1] == (gen_i[k] | (prop_i[k] & carry_o[k])));
    end
  end
endmodule

// File: rtl/mas_word_slice.sv
module mas_word_slice #(
  parameter int WORD_W = 17
) (
  input  logic [WORD_W-1:0] a_w,
  input  logic [WORD_W-1:0] b_w,
  input  logic [WORD_W-1:0] m_w,
  input  logic              sub_i,
  input  logic              c_dir_i,
  input  logic              c_cor_i,
  output logic              g_dir_o,
  output logic              p_dir_o,
  output logic              g_cor_o,
  output logic              p_cor_o,
  output logic [WORD_W-1:0] r_dir_o,
  output logic [WORD_W-1:0] r_cor_o
);
  logic [WORD_W-1:0] b_eff;
  logic [WORD_W:0]   t_dir;
  logic [WORD_W:0]   t_cor;

  always_comb begin
    b_eff   = sub_i ? ~b_w : b_w;
    t_dir   = {1'b0, a_w} + {1'b0, b_eff};
    g_dir_o = t_dir[WORD_W];
    p_dir_o = &t_dir[WORD_W-1:0];
    r_dir_o = t_dir[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, c_dir_i};
    t_cor   = {1'b0, r_dir_o} + {1'b0, m_w};
    g_cor_o = t_cor[WORD_W];
    p_cor_o = &t_cor[WORD_W-1:0];
    r_cor_o = t_cor[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, c_cor_i};
  end
endmodule

// File: rtl/modaddsub.sv
module modaddsub
  import modaddsub_pkg::*;
#(
  parameter int WORD_W = 17,
  parameter int NWORDS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en_i,
  input  logic                       sub_i,
  input  logic [WORD_W*NWORDS-1:0]   a_i,
  input  logic [WORD_W*NWORDS-1:0]   b_i,
  input  logic [WORD_W*NWORDS-1:0]   p_i,
  input  logic [WORD_W*NWORDS-1:0]   ip_i,
  output logic [WORD_W*NWORDS-1:0]   r_o
);
  localparam int NB = WORD_W * NWORDS;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  op_e op;
  assign op = op_e'(sub_i);

  logic [NWORDS-1:0] g_dir, p_dir, g_cor, p_cor;
  logic [NWORDS:0]   c_dir, c_cor;
  logic [NB-1:0]     r_dir, r_cor, r_sel, r_nxt, r_q;
  logic              take_cor;

  mas_carry_proj #(.NWORDS(NWORDS)) u_proj_dir (
    .gen_i  (g_dir),
    .prop_i (p_dir),
    .cin_i  (sub_i),
    .carry_o(c_dir)
  );

  mas_carry_proj #(.NWORDS(NWORDS)) u_proj_cor (
    .gen_i  (g_cor),
    .prop_i (p_cor),
    .cin_i  (1'b0),
    .carry_o(c_cor)
  );

  // add: correct when A+B overflowed 2^n or (A+B) mod 2^n >= P
  // sub: correct when the difference borrowed
  assign take_cor = (op == OP_SUB) ? ~c_dir[NWORDS] : (c_dir[NWORDS] | c_cor[NWORDS]);

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    logic [WORD_W-1:0] m_w;
    assign m_w = (op == OP_SUB) ? p_i[k*WORD_W +: WORD_W] : ip_i[k*WORD_W +: WORD_W];

    mas_word_slice #(.WORD_W(WORD_W)) u_slice (
      .a_w    (a_i[k*WORD_W +: WORD_W]),
      .b_w    (b_i[k*WORD_W +: WORD_W]),
      .m_w    (m_w),
      .sub_i  (sub_i),
      .c_dir_i(c_dir[k]),
      .c_cor_i(c_cor[k]),
      .g_dir_o(g_dir[k]),
      .p_dir_o(p_dir[k]),
      .g_cor_o(g_cor[k]),
      .p_cor_o(p_cor[k]),
      .r_dir_o(r_dir[k*WORD_W +: WORD_W]),
      .r_cor_o(r_cor[k*WORD_W +: WORD_W])
    );

    assign r_sel[k*WORD_W +: WORD_W] = take_cor ? r_cor[k*WORD_W +: WORD_W]
                                                : r_dir[k*WORD_W +: WORD_W];
  end

  always_comb begin
    r_nxt = r_q;
    if (en_i) r_nxt = r_sel;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) r_q <= '0;
    else             r_q <= r_nxt;
  end

  assign r_o = r_q;

  // checking aids: wide reference values for the clocked properties
  logic [NB+1:0] chk_sum, chk_dif;
  logic          chk_in_range;
  assign chk_sum      = {2'b00, a_i} + {2'b00, b_i};
  assign chk_dif      = {2'b00, a_i} + {2'b00, p_i} - {2'b00, b_i};
  assign chk_in_range = (a_i < p_i) && (b_i < p_i);

  // R3
  result_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en_i && chk_in_range) |=> (r_o < $past(p_i)));

  // R1
  add_value_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en_i && !sub_i && chk_in_range) |=>
      ({2'b00, r_o} == (($past(chk_sum) >= {2'b00, $past(p_i)}) ?
                         $past(chk_sum) - {2'b00, $past(p_i)} : $past(chk_sum))));

  // R2
  sub_value_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en_i && sub_i && chk_in_range) |=>
      ({2'b00, r_o} == (($past(chk_dif) >= {2'b00, $past(p_i)}) ?
                         $past(chk_dif) - {2'b00, $past(p_i)} : $past(chk_dif))));

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en_i |=> $stable(r_o));
endmodule

// File: tb/sim_modaddsub.sv
module sim_modaddsub;
  localparam int WORD_W = 17;
  localparam int NWORDS = 4;
  localparam int NB     = WORD_W * NWORDS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_i = 1'b0;
  logic          sub_i = 1'b0;
  logic [NB-1:0] a_i = '0, b_i = '0, p_i = '0, ip_i = '0;
  logic [NB-1:0] r_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R5 reset";
  logic  [NB-1:0] exp_q;
  bit    done = 1'b0;

  always #2 clk = ~clk;

  modaddsub #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .sub_i(sub_i),
    .a_i(a_i), .b_i(b_i), .p_i(p_i), .ip_i(ip_i), .r_o(r_o)
  );

  function automatic logic [NB-1:0] ref_f(logic [NB-1:0] a, logic [NB-1:0] b,
                                          logic [NB-1:0] p, logic s);
    logic [NB+1:0] x;
    if (!s) begin
      x = {2'b00, a} + {2'b00, b};
      if (x >= {2'b00, p}) x = x - {2'b00, p};
    end else if (a >= b) begin
      x = {2'b00, a} - {2'b00, b};
    end else begin
      x = {2'b00, a} + {2'b00, p} - {2'b00, b};
    end
    return x[NB-1:0];
  endfunction

  // behavioural model of the output register
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)    exp_q <= '0;
    else if (en_i) exp_q <= ref_f(a_i, b_i, p_i, sub_i);
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (r_o !== exp_q) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", tag, r_o, exp_q);
      end
    end
  end

  function automatic logic [NB-1:0] rnd_below(logic [NB-1:0] p);
    logic [95:0] w;
    w = {$urandom(), $urandom(), $urandom()};
    return w[NB-1:0] % p;
  endfunction

  task automatic set_mod(logic [NB-1:0] p);
    p_i  = p;
    ip_i = ~p + 1'b1;
  endtask

  task automatic drive(logic [NB-1:0] a, logic [NB-1:0] b, logic s, logic e, string t);
    @(negedge clk);
    #1;
    a_i = a; b_i = b; sub_i = s; en_i = e; tag = t;
  endtask

  initial begin
    logic [NB-1:0] pm;
    logic [NB-1:0] hold_a;
    set_mod({4'h9, 64'h1234_5678_9abc_def1});
    repeat (4) @(negedge clk);
    rst_n = 1'b1;                       // R5: stays 0 through sync release
    repeat (4) @(negedge clk);

    for (int i = 0; i < 40; i++) drive(rnd_below(p_i), rnd_below(p_i), 1'b0, 1'b1, "R1 R3 add random");
    for (int i = 0; i < 40; i++) drive(rnd_below(p_i), rnd_below(p_i), 1'b1, 1'b1, "R2 R3 sub random");

    hold_a = rnd_below(p_i);
    drive(hold_a, hold_a, 1'b1, 1'b1, "R7 sub A=B");
    drive('0, p_i - 1'b1, 1'b1, 1'b1, "R7 sub A=0");
    drive('0, 68'd5, 1'b1, 1'b1, "R7 sub A=0 small B");
    drive(p_i - 1'b1, 68'd1, 1'b0, 1'b1, "R7 add A+B=P");
    drive(p_i - 1'b1, p_i - 1'b1, 1'b0, 1'b1, "R7 add P-1 twice");
    drive(rnd_below(p_i), rnd_below(p_i), 1'b0, 1'b0, "R4 hold en low");
    drive(rnd_below(p_i), rnd_below(p_i), 1'b1, 1'b0, "R4 hold en low sub");

    // modulus near 2^n: sums overflow the n-bit range
    pm = {NB{1'b1}} - 68'd58;
    set_mod(pm);
    drive(pm - 1'b1, pm - 1'b1, 1'b0, 1'b1, "R8 add overflow 2^n");
    drive(pm - 1'b1, 68'd59, 1'b0, 1'b1, "R8 add overflow edge");
    drive(pm - 1'b1, 68'd1, 1'b0, 1'b1, "R8 add exact P");
    drive(68'd0, pm - 1'b1, 1'b1, 1'b1, "R8 sub full borrow");
    for (int i = 0; i < 30; i++) drive(rnd_below(pm), rnd_below(pm), i[0], 1'b1, "R8 near-2^n random");

    // word-boundary carry chain: low words all ones
    set_mod({4'hF, 64'hFFFF_FFFF_FFFF_FFC5});
    drive({4'h0, 64'h0000_0007_FFFF_FFFF}, 68'd1, 1'b0, 1'b1, "R6 carry across words");
    drive({4'h1, 64'h0000_0000_0000_0000}, 68'd1, 1'b1, 1'b1, "R6 borrow across words");

    // small modulus
    set_mod(68'd97);
    for (int i = 0; i < 20; i++) drive(rnd_below(p_i), rnd_below(p_i), i[0], 1'b1, "R1 R2 small P");

    drive('0, '0, 1'b0, 1'b0, "R4 idle");
    @(negedge clk);
    rst_n = 1'b0;
    tag = "R5 reset again";
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule